// File: doc/BRIEF.md
# Display Command Stream Decoder

This block takes a byte stream of display-controller commands and turns it into register state for a display timing engine. Every command starts with a sync byte. The decoder recognises three kinds of command: a single-byte register write, a lock/unlock control write, and a short pixel-copy command. It accepts one byte per clock, and the `in_ready` output is held high.

Register writes always land in a shadow register file. While the video registers are unlocked, a write also takes effect at once in the active copy. After a lock, writes stay staged. An unlock then moves every staged byte into the active registers in a single clock edge, so a whole mode change appears at one instant.

The active values are brought out as ports: the colour depth select, two 24-bit framebuffer base pointers, an array of 16-bit timing comparator words and the blank mode. Each parsed copy command gives a one-cycle pulse together with its source, count and destination fields.

Top module: `dcmd_decoder`

## Requirements
- R1: A byte other than 0xAF, arriving where a command should start, is discarded. It causes no register change and no error.
- R2: The sequence 0xAF, 0x20, address, value is a register write. While unlocked, the targeted output shows the new value in the cycle after the edge that accepts the value byte.
- R3: Address 0x00 holds the 8-bit colour depth select (`depth_sel`). The value 0 means 16 bits per pixel.
- R4: Each base pointer is 24 bits wide, and its most significant byte sits at the lowest address. `fb_base_a` uses 0x20/0x21/0x22 and `fb_base_b` uses 0x26/0x27/0x28.
- R5: Timing word k (k = 0..13) lives at addresses 0x01+2k and 0x02+2k. The byte at the lower address is bits 15:8.
- R6: Timing word 13 (0x1B/0x1C) has the reversed order: the byte at 0x1B is bits 7:0 and the byte at 0x1C is bits 15:8.
- R7: Address 0x1F holds the 8-bit blank mode (`blank_mode`).
- R8: Writing 0x00 to address 0xFF locks the registers. Later writes are staged, and no active output changes. Writing 0xFF to 0xFF unlocks and copies all staged bytes to the outputs in one edge. Any other value written to 0xFF, and any write to an unmapped address, changes no output.
- R9: The sequence 0xAF, 0x6A and then 7 payload bytes is a copy command. The payload is a 24-bit source (high byte first), an 8-bit count and a 24-bit destination (high byte first). `copy_pulse` is high for exactly the one cycle after the last payload byte is accepted, and the fields are valid in that cycle.
- R10: A 0xAF that follows a sync byte, where an opcode is expected, starts a fresh command. The lone sync byte has no effect and raises no error. Payload and value bytes equal to 0xAF are taken as data.
- R11: An opcode other than 0x20, 0x6A or 0xAF sets `err_flag` from the next cycle until reset. The parser then discards bytes until the next 0xAF.
- R12: `in_ready` is always 1, and a byte is consumed only on a clock edge where `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Always high; one byte per clock |
| depth_sel | output | 8 | Active colour depth select |
| fb_base_a | output | 24 | Active 16bpp framebuffer base |
| fb_base_b | output | 24 | Active 8bpp framebuffer base |
| tword | output | 14x16 | Active timing comparator words |
| blank_mode | output | 8 | Active blank mode |
| copy_pulse | output | 1 | One-cycle strobe per copy command |
| copy_src | output | 24 | Copy source address |
| copy_cnt | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
Several properties are checked on every cycle by the assertions. While the registers are locked and no unlock arrives, no active output moves. The error flag never falls and only rises after an accepted byte. A copy pulse never lasts two cycles and only follows an accepted byte.

Other behaviour can only be shown by the bench's scenarios. These include the byte order of each multi-byte register, the reversed word, the exact instant of the unlock commit, the handling of padding and garbage bytes, resynchronisation after a bad opcode, and the values of the copy fields.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;
   typedef enum logic [2:0] {
      PS_HUNT,
      PS_OPC,
      PS_RADDR,
      PS_RVAL,
      PS_COPY
   } pstate_t;

   localparam logic [7:0] SYNC_BYTE   = 8'hAF;
   localparam logic [7:0] OP_REGWR    = 8'h20;
   localparam logic [7:0] OP_COPY     = 8'h6A;
   localparam logic [7:0] CTRL_ADDR   = 8'hFF;
   localparam logic [7:0] CTRL_LOCK   = 8'h00;
   localparam logic [7:0] CTRL_UNLOCK = 8'hFF;
endpackage

// File: rtl/dcmd_parser.sv
module dcmd_parser
   import dcmd_pkg::*;
#(
   parameter int COPY_LEN = 7,
   localparam int IDX_W   = $clog2(COPY_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_en,
   input  logic [7:0]       byte_in,
   output logic             wr_en,
   output logic [7:0]       wr_addr,
   output logic [7:0]       wr_data,
   output logic             lock_p,
   output logic             unlock_p,
   output logic             pay_en,
   output logic [IDX_W-1:0] pay_idx,
   output logic             err_flag
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COPY_LEN - 1);

   if (COPY_LEN < 3) begin : g_len_chk
      $error("dcmd_parser: COPY_LEN must be at least 3");
   end

   pstate_t          st_q;
   logic [IDX_W-1:0] cnt_q;
   logic [7:0]       raddr_q;
   logic             err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PS_HUNT;
         cnt_q   <= '0;
         raddr_q <= '0;
         err_q   <= 1'b0;
      end else if (byte_en) begin
         case (st_q)
            PS_HUNT: begin
               if (byte_in == SYNC_BYTE) st_q <= PS_OPC;
            end
            PS_OPC: begin
               case (byte_in)
                  OP_REGWR:  st_q <= PS_RADDR;
                  OP_COPY: begin
                     st_q  <= PS_COPY;
                     cnt_q <= '0;
                  end
                  SYNC_BYTE: st_q <= PS_OPC;
                  default: begin
                     st_q  <= PS_HUNT;
                     err_q <= 1'b1;
                  end
               endcase
            end
            PS_RADDR: begin
               raddr_q <= byte_in;
               st_q    <= PS_RVAL;
            end
            PS_RVAL: st_q <= PS_HUNT;
            PS_COPY: begin
               if (cnt_q == LAST_IDX) st_q <= PS_HUNT;
               else                   cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= PS_HUNT;
         endcase
      end
   end

   logic val_byte;
   assign val_byte = byte_en && (st_q == PS_RVAL);

   assign wr_en    = val_byte && (raddr_q != CTRL_ADDR);
   assign wr_addr  = raddr_q;
   assign wr_data  = byte_in;
   assign lock_p   = val_byte && (raddr_q == CTRL_ADDR) && (byte_in == CTRL_LOCK);
   assign unlock_p = val_byte && (raddr_q == CTRL_ADDR) && (byte_in == CTRL_UNLOCK);
   assign pay_en   = byte_en && (st_q == PS_COPY);
   assign pay_idx  = cnt_q;
   assign err_flag = err_q;
endmodule

// File: rtl/dcmd_regfile.sv
module dcmd_regfile
   import dcmd_pkg::*;
#(
   parameter int         BASE_BYTES  = 3,
   parameter int         N_TWORDS    = 14,
   parameter logic [7:0] DEPTH_ADDR  = 8'h00,
   parameter logic [7:0] BASE_A_ADDR = 8'h20,
   parameter logic [7:0] BASE_B_ADDR = 8'h26,
   parameter logic [7:0] TW_BASE     = 8'h01,
   parameter logic [7:0] REV_ADDR    = 8'h1B,
   parameter logic [7:0] BLANK_ADDR  = 8'h1F,
   localparam int        BASE_W      = 8 * BASE_BYTES,
   localparam int        N_SLOTS     = 2 + 2 * BASE_BYTES + 2 * N_TWORDS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [7:0]                   wr_addr,
   input  logic [7:0]                   wr_data,
   input  logic                         lock_p,
   input  logic                         unlock_p,
   output logic                         locked,
   output logic [7:0]                   depth_sel,
   output logic [BASE_W-1:0]            fb_base_a,
   output logic [BASE_W-1:0]            fb_base_b,
   output logic [N_TWORDS-1:0][15:0]    tword,
   output logic [7:0]                   blank_mode
);
   function automatic logic [7:0] slot_addr(input int i);
      if (i == 0)                                  return DEPTH_ADDR;
      else if (i <= BASE_BYTES)                    return BASE_A_ADDR + 8'(i - 1);
      else if (i <= 2 * BASE_BYTES)                return BASE_B_ADDR + 8'(i - 1 - BASE_BYTES);
      else if (i <= 2 * BASE_BYTES + 2 * N_TWORDS) return TW_BASE + 8'(i - 1 - 2 * BASE_BYTES);
      else                                         return BLANK_ADDR;
   endfunction

   if (BASE_BYTES < 1 || BASE_BYTES > 4) begin : g_bb_chk
      $error("dcmd_regfile: BASE_BYTES out of range");
   end
   if (N_TWORDS < 1 || N_TWORDS > 64) begin : g_tw_chk
      $error("dcmd_regfile: N_TWORDS out of range");
   end

   logic locked_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        locked_q <= 1'b0;
      else if (unlock_p) locked_q <= 1'b0;
      else if (lock_p)   locked_q <= 1'b1;
   end
   assign locked = locked_q;

   logic [N_SLOTS-1:0][7:0] act_all;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      localparam logic [7:0] SA = slot_addr(g);
      if (SA == CTRL_ADDR) begin : g_addr_chk
         $error("dcmd_regfile: register slot collides with control address");
      end
      logic       hit;
      logic [7:0] shd_q;
      logic [7:0] act_q;
      assign hit = wr_en && (wr_addr == SA);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (hit) shd_q <= wr_data;
            if (unlock_p)             act_q <= shd_q;
            else if (hit && !locked_q) act_q <= wr_data;
         end
      end
      assign act_all[g] = act_q;
   end

   assign depth_sel  = act_all[0];
   assign blank_mode = act_all[N_SLOTS-1];

   for (genvar j = 0; j < BASE_BYTES; j++) begin : g_base
      assign fb_base_a[8*(BASE_BYTES-1-j) +: 8] = act_all[1 + j];
      assign fb_base_b[8*(BASE_BYTES-1-j) +: 8] = act_all[1 + BASE_BYTES + j];
   end

   for (genvar k = 0; k < N_TWORDS; k++) begin : g_tw
      localparam int         S0 = 2 * BASE_BYTES + 1 + 2 * k;
      localparam logic [7:0] LO = TW_BASE + 8'(2 * k);
      if (LO == REV_ADDR) begin : g_rev
         assign tword[k] = {act_all[S0+1], act_all[S0]};
      end else begin : g_fwd
         assign tword[k] = {act_all[S0], act_all[S0+1]};
      end
   end
endmodule

// File: rtl/dcmd_copy_collect.sv
module dcmd_copy_collect #(
   parameter int  CP_ADDR_BYTES = 3,
   localparam int COPY_LEN      = 2 * CP_ADDR_BYTES + 1,
   localparam int IDX_W         = $clog2(COPY_LEN),
   localparam int CP_W          = 8 * CP_ADDR_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pay_en,
   input  logic [IDX_W-1:0] pay_idx,
   input  logic [7:0]       pay_byte,
   output logic             copy_pulse,
   output logic [CP_W-1:0]  copy_src,
   output logic [7:0]       copy_cnt,
   output logic [CP_W-1:0]  copy_dst
);
   localparam logic [IDX_W-1:0] CNT_IDX  = IDX_W'(CP_ADDR_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COPY_LEN - 1);

   if (CP_ADDR_BYTES < 1 || CP_ADDR_BYTES > 4) begin : g_cp_chk
      $error("dcmd_copy_collect: CP_ADDR_BYTES out of range");
   end

   for (genvar j = 0; j < CP_ADDR_BYTES; j++) begin : g_addr
      localparam logic [IDX_W-1:0] SI = IDX_W'(j);
      localparam logic [IDX_W-1:0] DI = IDX_W'(CP_ADDR_BYTES + 1 + j);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            copy_src[8*(CP_ADDR_BYTES-1-j) +: 8] <= '0;
            copy_dst[8*(CP_ADDR_BYTES-1-j) +: 8] <= '0;
         end else if (pay_en) begin
            if (pay_idx == SI) copy_src[8*(CP_ADDR_BYTES-1-j) +: 8] <= pay_byte;
            if (pay_idx == DI) copy_dst[8*(CP_ADDR_BYTES-1-j) +: 8] <= pay_byte;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         copy_cnt   <= '0;
         copy_pulse <= 1'b0;
      end else begin
         if (pay_en && pay_idx == CNT_IDX) copy_cnt <= pay_byte;
         copy_pulse <= pay_en && (pay_idx == LAST_IDX);
      end
   end
endmodule

// File: rtl/dcmd_decoder.sv
module dcmd_decoder
   import dcmd_pkg::*;
#(
   parameter int         BASE_BYTES    = 3,
   parameter int         CP_ADDR_BYTES = 3,
   parameter int         N_TWORDS      = 14,
   parameter logic [7:0] DEPTH_ADDR    = 8'h00,
   parameter logic [7:0] BASE_A_ADDR   = 8'h20,
   parameter logic [7:0] BASE_B_ADDR   = 8'h26,
   parameter logic [7:0] TW_BASE       = 8'h01,
   parameter logic [7:0] REV_ADDR      = 8'h1B,
   parameter logic [7:0] BLANK_ADDR    = 8'h1F,
   localparam int        BASE_W        = 8 * BASE_BYTES,
   localparam int        CP_W          = 8 * CP_ADDR_BYTES
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [7:0]                in_data,
   output logic                      in_ready,
   output logic [7:0]                depth_sel,
   output logic [BASE_W-1:0]         fb_base_a,
   output logic [BASE_W-1:0]         fb_base_b,
   output logic [N_TWORDS-1:0][15:0] tword,
   output logic [7:0]                blank_mode,
   output logic                      copy_pulse,
   output logic [CP_W-1:0]           copy_src,
   output logic [7:0]                copy_cnt,
   output logic [CP_W-1:0]           copy_dst,
   output logic                      err_flag
);
   localparam int COPY_LEN = 2 * CP_ADDR_BYTES + 1;
   localparam int IDX_W    = $clog2(COPY_LEN);

   logic             byte_en;
   logic             wr_en;
   logic [7:0]       wr_addr;
   logic [7:0]       wr_data;
   logic             lock_p;
   logic             unlock_p;
   logic             pay_en;
   logic [IDX_W-1:0] pay_idx;
   logic             vid_locked;

   assign in_ready = 1'b1;
   assign byte_en  = in_valid;

   dcmd_parser #(.COPY_LEN(COPY_LEN)) u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_en  (byte_en),
      .byte_in  (in_data),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .lock_p   (lock_p),
      .unlock_p (unlock_p),
      .pay_en   (pay_en),
      .pay_idx  (pay_idx),
      .err_flag (err_flag)
   );

   dcmd_regfile #(
      .BASE_BYTES  (BASE_BYTES),
      .N_TWORDS    (N_TWORDS),
      .DEPTH_ADDR  (DEPTH_ADDR),
      .BASE_A_ADDR (BASE_A_ADDR),
      .BASE_B_ADDR (BASE_B_ADDR),
      .TW_BASE     (TW_BASE),
      .REV_ADDR    (REV_ADDR),
      .BLANK_ADDR  (BLANK_ADDR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .lock_p     (lock_p),
      .unlock_p   (unlock_p),
      .locked     (vid_locked),
      .depth_sel  (depth_sel),
      .fb_base_a  (fb_base_a),
      .fb_base_b  (fb_base_b),
      .tword      (tword),
      .blank_mode (blank_mode)
   );

   dcmd_copy_collect #(.CP_ADDR_BYTES(CP_ADDR_BYTES)) u_copy (
      .clk        (clk),
      .rst_n      (rst_n),
      .pay_en     (pay_en),
      .pay_idx    (pay_idx),
      .pay_byte   (in_data),
      .copy_pulse (copy_pulse),
      .copy_src   (copy_src),
      .copy_cnt   (copy_cnt),
      .copy_dst   (copy_dst)
   );
endmodule

// File: rtl/dcmd_decoder_chk.sv
module dcmd_decoder_chk #(
   parameter int BASE_W   = 24,
   parameter int N_TWORDS = 14
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      vid_locked,
   input logic                      unlock_p,
   input logic [7:0]                depth_sel,
   input logic [BASE_W-1:0]         fb_base_a,
   input logic [BASE_W-1:0]         fb_base_b,
   input logic [N_TWORDS-1:0][15:0] tword,
   input logic [7:0]                blank_mode,
   input logic                      copy_pulse,
   input logic                      err_flag
);
   // R8: staged writes leave the active outputs alone until an unlock
   p_locked_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_locked && !unlock_p) |=> ($stable(depth_sel) && $stable(fb_base_a) &&
                                     $stable(fb_base_b) && $stable(tword) &&
                                     $stable(blank_mode)));

   // R11: error flag never clears outside reset
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R11: error rises only after an accepted opcode byte
   p_err_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(in_valid));

   // R9: copy strobe lasts one cycle
   p_copy_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      copy_pulse |=> !copy_pulse);

   // R9: copy strobe follows an accepted payload byte
   p_copy_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(copy_pulse) |-> $past(in_valid));
endmodule

bind dcmd_decoder dcmd_decoder_chk #(
   .BASE_W   (BASE_W),
   .N_TWORDS (N_TWORDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .vid_locked (vid_locked),
   .unlock_p   (unlock_p),
   .depth_sel  (depth_sel),
   .fb_base_a  (fb_base_a),
   .fb_base_b  (fb_base_b),
   .tword      (tword),
   .blank_mode (blank_mode),
   .copy_pulse (copy_pulse),
   .err_flag   (err_flag)
);

// File: tb/tb_dcmd_decoder.sv
module tb_dcmd_decoder;
   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic [7:0]        in_data;
   logic              in_ready;
   logic [7:0]        depth_sel;
   logic [23:0]       fb_base_a;
   logic [23:0]       fb_base_b;
   logic [13:0][15:0] tword;
   logic [7:0]        blank_mode;
   logic              copy_pulse;
   logic [23:0]       copy_src;
   logic [7:0]        copy_cnt;
   logic [23:0]       copy_dst;
   logic              err_flag;

   always #4 clk = ~clk;

   dcmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .depth_sel(depth_sel), .fb_base_a(fb_base_a),
      .fb_base_b(fb_base_b), .tword(tword), .blank_mode(blank_mode),
      .copy_pulse(copy_pulse), .copy_src(copy_src), .copy_cnt(copy_cnt),
      .copy_dst(copy_dst), .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // {addr, value, output selector, expected}; selector 6 = depth, ignored-write case
   localparam int NV = 14;
   localparam logic [43:0] VEC [NV] = '{
      {8'h00, 8'h01, 4'd0, 24'h000001},
      {8'h20, 8'h12, 4'd1, 24'h120000},
      {8'h21, 8'h34, 4'd1, 24'h123400},
      {8'h22, 8'h56, 4'd1, 24'h123456},
      {8'h26, 8'hAB, 4'd2, 24'hAB0000},
      {8'h27, 8'hCD, 4'd2, 24'hABCD00},
      {8'h28, 8'hEF, 4'd2, 24'hABCDEF},
      {8'h01, 8'h11, 4'd3, 24'h001100},
      {8'h02, 8'h22, 4'd3, 24'h001122},
      {8'h1B, 8'h78, 4'd4, 24'h000078},
      {8'h1C, 8'h9A, 4'd4, 24'h009A78},
      {8'h1F, 8'h05, 4'd5, 24'h000005},
      {8'h30, 8'hEE, 4'd6, 24'h000001},
      {8'hFF, 8'h55, 4'd6, 24'h000001}
   };

   function automatic string sel_tag(input logic [3:0] s);
      case (s)
         4'd0: return "R3 depth";
         4'd1: return "R4 base_a";
         4'd2: return "R4 base_b";
         4'd3: return "R5 word0";
         4'd4: return "R6 word13";
         4'd5: return "R7 blank";
         default: return "R8 ignored write";
      endcase
   endfunction

   function automatic logic [23:0] sel_val(input logic [3:0] s);
      case (s)
         4'd0, 4'd6: return {16'h0, depth_sel};
         4'd1: return fb_base_a;
         4'd2: return fb_base_b;
         4'd3: return {8'h0, tword[0]};
         4'd4: return {8'h0, tword[13]};
         default: return {16'h0, blank_mode};
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      in_valid = 1'b1;
      in_data  = b;
      @(negedge clk);
   endtask

   task automatic rest();
      in_valid = 1'b0;
      in_data  = 8'h00;
   endtask

   // R2 register write frame
   task automatic cmd_wr(input logic [7:0] a, input logic [7:0] v);
      put(8'hAF); put(8'h20); put(a); put(v);
      rest();
   endtask

   initial begin
      rst_n = 1'b0;
      rest();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 ready", {31'h0, in_ready}, 32'h1);
      check("reset depth", {24'h0, depth_sel}, 32'h0);
      check("reset base_a", {8'h0, fb_base_a}, 32'h0);
      check("reset err", {31'h0, err_flag}, 32'h0);
      check("reset copy_pulse", {31'h0, copy_pulse}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         cmd_wr(VEC[i][43:36], VEC[i][35:28]);
         check(sel_tag(VEC[i][27:24]), {8'h0, sel_val(VEC[i][27:24])}, {8'h0, VEC[i][23:0]});
      end

      // R8 lock, staged writes, unlock commit
      cmd_wr(8'hFF, 8'h00);
      cmd_wr(8'h00, 8'h07);
      check("R8 locked depth held", {24'h0, depth_sel}, 32'h01);
      cmd_wr(8'h1F, 8'h09);
      check("R8 locked blank held", {24'h0, blank_mode}, 32'h05);
      cmd_wr(8'h22, 8'h99);
      check("R8 locked base held", {8'h0, fb_base_a}, 32'h123456);
      cmd_wr(8'hFF, 8'hFF);
      check("R8 commit depth", {24'h0, depth_sel}, 32'h07);
      check("R8 commit blank", {24'h0, blank_mode}, 32'h09);
      check("R8 commit base", {8'h0, fb_base_a}, 32'h123499);
      cmd_wr(8'h00, 8'h02);
      check("R2 unlocked write", {24'h0, depth_sel}, 32'h02);

      // R1 garbage before sync
      put(8'h00); put(8'h13); put(8'h20); rest();
      check("R1 garbage no change", {24'h0, depth_sel}, 32'h02);
      cmd_wr(8'h00, 8'h03);
      check("R1 after garbage", {24'h0, depth_sel}, 32'h03);
      check("R1 no error", {31'h0, err_flag}, 32'h0);

      // R12 bubbles in valid
      put(8'hAF); rest(); in_data = 8'h6A; @(negedge clk);
      put(8'h20); rest(); @(negedge clk); @(negedge clk);
      put(8'h00); put(8'h0C); rest();
      check("R12 gapped stream", {24'h0, depth_sel}, 32'h0C);

      // R10 padding sync and 0xAF as data
      put(8'hAF); put(8'hAF); put(8'h20); put(8'h1F); put(8'hAF); rest();
      check("R10 padding then write", {24'h0, blank_mode}, 32'hAF);
      check("R10 no error", {31'h0, err_flag}, 32'h0);

      // R9 copy command
      put(8'hAF); put(8'h6A);
      put(8'h12); put(8'h34); put(8'h56); put(8'h04);
      put(8'hAB); put(8'hCD); put(8'hEF); rest();
      check("R9 pulse", {31'h0, copy_pulse}, 32'h1);
      check("R9 src", {8'h0, copy_src}, 32'h123456);
      check("R9 cnt", {24'h0, copy_cnt}, 32'h04);
      check("R9 dst", {8'h0, copy_dst}, 32'hABCDEF);
      @(negedge clk);
      check("R9 pulse one cycle", {31'h0, copy_pulse}, 32'h0);
      check("R9 no reg change", {24'h0, depth_sel}, 32'h0C);

      // R11 unknown opcode
      put(8'hAF); put(8'h55); rest();
      check("R11 err set", {31'h0, err_flag}, 32'h1);
      put(8'h20); put(8'h00); put(8'h01); rest();
      check("R11 resync discards", {24'h0, depth_sel}, 32'h0C);
      cmd_wr(8'h00, 8'h0E);
      check("R11 resync write", {24'h0, depth_sel}, 32'h0E);
      check("R11 err sticky", {31'h0, err_flag}, 32'h1);

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset clears err", {31'h0, err_flag}, 32'h0);
      check("reset clears depth", {24'h0, depth_sel}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule